// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt request flags for an 8-bit microcontroller core. The sources are two external interrupt inputs, two timer overflows and one serial-unit request. Each flag arrives already detected, because edge and level detection sit upstream. The CPU programs a source-enable register, with a global enable in its top bit, and a priority register. It can reach both with byte accesses and with single-bit accesses. The controller presents the best pending enabled request as a request strobe, a 16-bit vector address and the level of that request.

Two in-service flags record whether a low-level or a high-level handler is running. When the CPU acknowledges the presented request, the flag for that request's level is set. While a low-level handler runs, only high-level requests are presented. While a high-level handler runs, nothing is presented. A return pulse from the CPU ends the innermost active service. Nested service therefore unwinds correctly.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, the enable register reads 60h at byte address A8h and the priority register reads E0h at byte address B8h. No request is presented and neither in-service flag is set.
- R2: A byte write to A8h stores data bit 7 as the global enable and bits 4..0 as the source enables. Bits 6..5 always read 1. A byte write to B8h stores bits 4..0 as the source priorities, and bits 7..5 always read 1. Reads of any other address return 00h, and writes to any other address change nothing.
- R3: A bit write at bit address A8h+n sets or clears enable bit n (n = 0..4 or 7). A bit write at B8h+n sets or clears priority bit n (n = 0..4). Bit writes to the unimplemented positions change nothing.
- R4: A source is eligible only when its flag, its enable bit and the global enable bit are all 1.
- R5: Source index k has vector 0003h + 8·k. The indices are: 0 for external interrupt 0, 1 for timer 0, 2 for external interrupt 1, 3 for timer 1 and 4 for the serial unit.
- R6: An eligible source with priority bit 1 (high level) wins over every low-level source. Within one level, the lowest index wins. `irq_level` is 1 for a high-level winner.
- R7: While only low-level service is active, only eligible high-level sources are presented.
- R8: While high-level service is active, `irq_req` stays 0.
- R9: `irq_ack` while `irq_req` is 1 sets the in-service flag of the presented level at the next clock.
- R10: A `reti` pulse clears the high in-service flag if it is set, and otherwise clears the low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Byte write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| bit_addr | input | 8 | Bit address for single-bit write |
| bit_wr | input | 1 | Bit write strobe |
| bit_wdata | input | 1 | Bit write value |
| req_flags | input | 5 | Pending request flags, index order as in R5 |
| irq_ack | input | 1 | CPU accepts the presented request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | A request is presented |
| irq_vector | output | 16 | Vector address of the presented request |
| irq_level | output | 1 | Level of the presented request (1 = high) |

## Verification
The assertions take three things for granted. `irq_ack` is raised only while a request is presented. It never falls in the same cycle as a `reti` pulse. A `reti` pulse comes only when some service is active. The stimulus holds to these rules by acknowledging only after it has seen `irq_req` high in the same cycle, and by issuing returns only inside the nesting that it built up. Byte and bit writes are never issued in the same cycle. Flag patterns come from a shift-register sequence, and they change only at the falling edge.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int          NSRC     = 5,
  parameter logic [7:0]  EN_ADDR  = 8'hA8,
  parameter logic [7:0]  PRI_ADDR = 8'hB8,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [7:0]      bit_addr,
  input  logic            bit_wr,
  input  logic            bit_wdata,
  input  logic [NSRC-1:0] req_flags,
  input  logic            irq_ack,
  input  logic            reti,
  output logic            irq_req,
  output logic [15:0]     irq_vector,
  output logic            irq_level
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] src_en, src_pri;
  logic            glob_en;
  logic            ins_hi, ins_lo;

  logic [NSRC-1:0] elig, hi_cand, lo_cand;
  logic            hi_any, lo_any;
  logic [IW-1:0]   hi_idx, lo_idx, sel_idx;

  wire [2:0] bsel   = bit_addr[2:0];
  wire       bit_en = bit_wr && (bit_addr[7:3] == EN_ADDR[7:3]);
  wire       bit_pr = bit_wr && (bit_addr[7:3] == PRI_ADDR[7:3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_en  <= '0;
      src_pri <= '0;
      glob_en <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == EN_ADDR) begin
        glob_en <= reg_wdata[7];
        src_en  <= reg_wdata[NSRC-1:0];
      end
      if (reg_addr == PRI_ADDR) src_pri <= reg_wdata[NSRC-1:0];
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (bit_en && bsel == 3'(i)) src_en[i]  <= bit_wdata;
        if (bit_pr && bsel == 3'(i)) src_pri[i] <= bit_wdata;
      end
      if (bit_en && bsel == 3'd7) glob_en <= bit_wdata;
    end
  end

  always_comb begin
    if (reg_addr == EN_ADDR)       reg_rdata = {glob_en, {(7-NSRC){1'b1}}, src_en};
    else if (reg_addr == PRI_ADDR) reg_rdata = {{(8-NSRC){1'b1}}, src_pri};
    else                           reg_rdata = 8'h00;
  end

  assign elig    = req_flags & src_en & {NSRC{glob_en}};
  assign hi_cand = elig & src_pri;
  assign lo_cand = elig & ~src_pri;

  always_comb begin
    hi_any = 1'b0; lo_any = 1'b0;
    hi_idx = '0;   lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hi_cand[i]) begin hi_any = 1'b1; hi_idx = IW'(i); end
      if (lo_cand[i]) begin lo_any = 1'b1; lo_idx = IW'(i); end
    end
  end

  assign irq_level  = hi_any;
  assign irq_req    = !ins_hi && (hi_any || (lo_any && !ins_lo));
  assign sel_idx    = hi_any ? hi_idx : lo_idx;
  assign irq_vector = irq_req ? VEC_BASE + 16'(sel_idx) * 16'(VEC_STEP) : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else if (irq_ack && irq_req) begin
      if (irq_level) ins_hi <= 1'b1;
      else           ins_lo <= 1'b1;
    end else if (reti) begin
      if (ins_hi) ins_hi <= 1'b0;
      else        ins_lo <= 1'b0;
    end
  end
endmodule

module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic        irq_level,
  input logic [15:0] irq_vector,
  input logic        irq_ack,
  input logic        reti,
  input logic        ins_hi,
  input logic        ins_lo,
  input logic        glob_en
);
  a_r5_vector_grid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'd3 && irq_vector <= 16'h0023));
  a_r4_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glob_en);
  a_r8_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !irq_req);
  a_r7_lo_only_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && ins_lo) |-> irq_level);
  a_r9_ack_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && irq_level) |=> ins_hi);
  a_r9_ack_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !irq_level) |=> ins_lo);
  a_r10_reti_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && ins_hi && !irq_ack) |=> !ins_hi);
  a_r10_reti_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ins_hi && ins_lo && !irq_ack) |=> !ins_lo);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_level(irq_level),
  .irq_vector(irq_vector), .irq_ack(irq_ack), .reti(reti),
  .ins_hi(ins_hi), .ins_lo(ins_lo), .glob_en(glob_en)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, bit_addr = 8'h00;
  logic reg_wr = 1'b0, bit_wr = 1'b0, bit_wdata = 1'b0;
  logic [4:0] req_flags = 5'h00;
  logic irq_ack = 1'b0, reti = 1'b0;
  logic [7:0] reg_rdata;
  logic irq_req, irq_level;
  logic [15:0] irq_vector;

  int checks = 0, errors = 0;
  bit m_ea, m_hi, m_lo;
  bit [4:0] m_en, m_pri;
  bit e_req, e_lvl;
  int e_idx;
  logic [15:0] e_vec;
  logic [7:0] e_rd;

  always #2 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_addr(bit_addr),
    .bit_wr(bit_wr), .bit_wdata(bit_wdata), .req_flags(req_flags),
    .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req),
    .irq_vector(irq_vector), .irq_level(irq_level));

  function automatic void model_outputs();
    int hi = -1, lo = -1;
    for (int k = 4; k >= 0; k--) begin
      if (req_flags[k] && m_en[k] && m_ea) begin
        if (m_pri[k]) hi = k; else lo = k;
      end
    end
    e_lvl = (hi >= 0);
    e_idx = (hi >= 0) ? hi : lo;
    e_req = !m_hi && (hi >= 0 || (lo >= 0 && !m_lo));
    e_vec = e_req ? 16'(3 + 8 * e_idx) : 16'h0000;
    if (reg_addr == 8'hA8)      e_rd = {m_ea, 2'b11, m_en};
    else if (reg_addr == 8'hB8) e_rd = {3'b111, m_pri};
    else                        e_rd = 8'h00;
  endfunction

  always @(posedge clk) begin
    model_outputs();
    if (!rst_n) begin
      m_ea = 0; m_en = 0; m_pri = 0; m_hi = 0; m_lo = 0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == 8'hA8) begin m_ea = reg_wdata[7]; m_en = reg_wdata[4:0]; end
        if (reg_addr == 8'hB8) m_pri = reg_wdata[4:0];
      end else if (bit_wr) begin
        if (bit_addr >= 8'hA8 && bit_addr <= 8'hAC) m_en[bit_addr - 8'hA8] = bit_wdata;
        if (bit_addr == 8'hAF) m_ea = bit_wdata;
        if (bit_addr >= 8'hB8 && bit_addr <= 8'hBC) m_pri[bit_addr - 8'hB8] = bit_wdata;
      end
      if (irq_ack && e_req) begin
        if (e_lvl) m_hi = 1; else m_lo = 1;
      end else if (reti) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
    end
  end

  task automatic check(input string tag);
    #1;
    model_outputs();
    checks++;
    if (irq_req !== e_req || reg_rdata !== e_rd ||
        (e_req && (irq_vector !== e_vec || irq_level !== e_lvl))) begin
      errors++;
      $display("FAIL %s: req=%b vec=%h lvl=%b rd=%h expected req=%b vec=%h lvl=%b rd=%h",
               tag, irq_req, irq_vector, irq_level, reg_rdata, e_req, e_vec, e_lvl, e_rd);
    end
  endtask

  task automatic tick(input string tag);
    check(tag);
    @(negedge clk);
    reg_wr = 0; bit_wr = 0; irq_ack = 0; reti = 0;
  endtask

  task automatic wbyte(input logic [7:0] a, input logic [7:0] d, input string tag);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(tag);
  endtask

  task automatic wbit(input logic [7:0] a, input bit v, input string tag);
    bit_addr = a; bit_wdata = v; bit_wr = 1; tick(tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lfsr = 8'h5A;
    @(negedge clk); @(negedge clk);
    reg_addr = 8'hA8; tick("R1 reset enable");
    rst_n = 1;
    reg_addr = 8'hA8; tick("R1 enable reset value");
    reg_addr = 8'hB8; req_flags = 5'h1F; tick("R1 priority reset value, no request");

    wbyte(8'hA8, 8'hFF, "R2 write enable");
    reg_addr = 8'hA8; tick("R2 enable readback");
    wbyte(8'hA8, 8'h00, "R2 clear enable");
    reg_addr = 8'hA8; tick("R2 bits 6..5 read 1");
    wbyte(8'hB8, 8'h15, "R2 write priority");
    reg_addr = 8'hB8; tick("R2 priority readback");
    wbyte(8'h90, 8'hFF, "R2 stray write");
    reg_addr = 8'h90; tick("R2 other address reads 0");
    reg_addr = 8'hA8; tick("R2 enable untouched by stray write");
    wbyte(8'hB8, 8'h00, "R2 clear priority");

    wbit(8'hAD, 1'b0, "R3 unimplemented enable bit");
    reg_addr = 8'hA8; tick("R3 unimplemented bit ignored");
    wbit(8'hBD, 1'b1, "R3 unimplemented priority bit");
    reg_addr = 8'hB8; tick("R3 priority unchanged");
    wbit(8'hAA, 1'b1, "R3 enable bit 2");
    reg_addr = 8'hA8; req_flags = 5'h04; tick("R4 no request without global enable");
    wbit(8'hAF, 1'b1, "R3 global enable bit");
    reg_addr = 8'hA8; tick("R4 request with global enable");
    req_flags = 5'h1B; tick("R4 flag without its enable");

    wbyte(8'hA8, 8'h9F, "R5 enable all");
    for (int k = 0; k < 5; k++) begin
      req_flags = 5'(1 << k); tick("R5 single source vector");
    end
    req_flags = 5'h1E; tick("R6 lowest index wins");
    wbyte(8'hB8, 8'h08, "R6 source 3 high");
    req_flags = 5'h1F; tick("R6 high beats low");
    wbit(8'hBC, 1'b1, "R3 priority bit 4");
    req_flags = 5'h11; tick("R6 lowest high wins");

    req_flags = 5'h01; tick("R9 present low request");
    irq_ack = 1; tick("R9 ack low");
    tick("R7 low in service masks low");
    req_flags = 5'h03; tick("R7 low still masked");
    req_flags = 5'h09; tick("R7 high preempts low");
    irq_ack = 1; tick("R9 ack high");
    req_flags = 5'h1F; tick("R8 high in service masks all");
    reti = 1; tick("R10 return clears high");
    req_flags = 5'h01; tick("R10 low still active");
    reti = 1; tick("R10 return clears low");
    tick("R10 low request visible again");

    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_flags = lfsr[4:0];
      reg_addr = lfsr[0] ? 8'hA8 : 8'hB8;
      if (lfsr[7:5] == 3'd1) begin reg_wdata = lfsr; reg_wr = 1; end
      else if (lfsr[7:5] == 3'd2) begin bit_addr = {4'hB, lfsr[1], lfsr[6:4]}; bit_wdata = lfsr[2]; bit_wr = 1; end
      else if (lfsr[7:5] == 3'd3 && (m_hi || m_lo)) reti = 1;
      #1; model_outputs();
      if (!reti && lfsr[6] && e_req) irq_ack = 1;
      tick("R6 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule